// File: doc/BRIEF.md
# DRAM Refresh Scheduler with Bus Arbitration

This block decides when a CAS-before-RAS refresh cycle goes out to external DRAM. A programmable interval counter splits time into refresh periods. Each period owes one refresh. The scheduler takes that refresh in the first idle slot of the external bus. If no idle slot appears before the period runs out, the refresh becomes overdue. The block then forces it in as soon as the bus cycle in flight reports completion.

The block also decides who owns the bus. A request from an external master is granted only when no software page mode is active and no refresh is starting or running. Page mode also holds back every refresh, so a refresh that falls due is deferred until page mode ends. An overdue refresh that meets a granted bus waits until the bus is handed back. A status output shows software that a refresh is overdue.

Top module: `rfsh_sched`

## Requirements
- R1: While `en_i` is low, no refresh starts and the interval count holds its value.
- R2: While `en_i` is high, the count steps down by one per clock. A clock that finds it at zero reloads it from `reload_i`. A period is therefore `reload_i`+1 clocks long, and the first enabled clock after reset (count zero) starts a period.
- R3: Each period owes one refresh. That refresh starts in the first clock of the period in which `bus_idle_i` is high, provided the scheduler is free, page mode is off and the bus is not granted.
- R4: If a period ends with its refresh not taken, `pending_o` goes high on the following clock. The overdue refresh then starts in the first eligible clock with `cyc_done_i` or `bus_idle_i` high. An overdue refresh is served before the refresh owed by the current period.
- R5: A refresh drives `cas_n_o` low (active low) starting the clock after it starts. `cas_n_o` stays low alone for PHASE_CLKS clocks. Both strobes are then low for PHASE_CLKS clocks, and then both return high.
- R6: While `page_mode_i` is high, no refresh starts.
- R7: `bus_grant_o` rises the clock after a clock with `bus_req_i` high, `page_mode_i` low, no refresh running and none starting. A refresh that starts in that same clock wins. While `page_mode_i` is high the grant is never given. Once given, the grant holds while `bus_req_i` stays high and drops the clock after it goes low.
- R8: While `bus_grant_o` is high, no refresh starts and both strobes stay high. An overdue refresh keeps waiting.
- R9: `pending_o` clears only on the clock after the last RAS clock of the overdue refresh. It stays high if another period expires unserved at that moment.
- R10: During reset the strobes are high, and `bus_grant_o` and `pending_o` are low. The count is zero and nothing is owed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| en_i | input | 1 | Refresh scheduling enable |
| reload_i | input | CNT_W | Interval reload value |
| bus_idle_i | input | 1 | External bus has an idle slot this clock |
| cyc_done_i | input | 1 | Bus cycle in progress completes this clock |
| page_mode_i | input | 1 | Software page mode active |
| bus_req_i | input | 1 | External master requests the bus |
| cas_n_o | output | 1 | Refresh column strobe, active low |
| ras_n_o | output | 1 | Refresh row strobe, active low |
| bus_grant_o | output | 1 | Bus handed to the external master |
| pending_o | output | 1 | Overdue refresh outstanding |

## Verification
The assertions take for granted that page mode is only raised by the bus owner, never while the grant is out. They also assume all control inputs are two-state after reset. The stimulus keeps to this by forcing `page_mode_i` low in any clock where `bus_grant_o` was seen high. Every other input, including the reload value, is random or directed. Long page-mode stretches and withheld idle slots push refreshes into the overdue path.

// File: rtl/rfsh_pkg.sv
package rfsh_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_CAS  = 2'd1,
    PH_RAS  = 2'd2
  } rfsh_ph_e;
endpackage

// File: rtl/rfsh_interval.sv
// Interval down-counter: steps while enabled, reloads at zero (R1, R2).
module rfsh_interval #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic [CNT_W-1:0] reload_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             at_zero;

  assign at_zero = (cnt_q == '0);
  assign wrap_o  = en_i && at_zero;
  assign cnt_o   = cnt_q;

  always_comb begin
    cnt_d = cnt_q;
    if (en_i) begin
      if (at_zero) cnt_d = reload_i;
      else         cnt_d = cnt_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt_q <= '0;
    else if (en_i) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/rfsh_strobe_fsm.sv
// CAS-then-RAS strobe sequencer (R5).
module rfsh_strobe_fsm
  import rfsh_pkg::*;
#(
  parameter int PHASE_CLKS = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic idle_o,
  output logic fin_o,
  output logic cas_n_o,
  output logic ras_n_o
);
  localparam int PC_W = (PHASE_CLKS > 1) ? $clog2(PHASE_CLKS) : 1;
  localparam logic [PC_W-1:0] PC_LAST = PC_W'(PHASE_CLKS - 1);

  rfsh_ph_e        ph_q, ph_d;
  logic [PC_W-1:0] pc_q, pc_d;
  logic            ph_end;

  assign ph_end  = (pc_q == PC_LAST);
  assign idle_o  = (ph_q == PH_IDLE);
  assign fin_o   = (ph_q == PH_RAS) && ph_end;
  assign cas_n_o = (ph_q == PH_IDLE);
  assign ras_n_o = (ph_q != PH_RAS);

  always_comb begin
    ph_d = ph_q;
    pc_d = pc_q;
    unique case (ph_q)
      PH_IDLE: begin
        if (start_i) begin
          ph_d = PH_CAS;
          pc_d = '0;
        end
      end
      PH_CAS: begin
        if (ph_end) begin
          ph_d = PH_RAS;
          pc_d = '0;
        end else begin
          pc_d = pc_q + PC_W'(1);
        end
      end
      PH_RAS: begin
        if (ph_end) begin
          ph_d = PH_IDLE;
          pc_d = '0;
        end else begin
          pc_d = pc_q + PC_W'(1);
        end
      end
      default: begin
        ph_d = PH_IDLE;
        pc_d = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q <= PH_IDLE;
      pc_q <= '0;
    end else begin
      ph_q <= ph_d;
      pc_q <= pc_d;
    end
  end
endmodule

// File: rtl/rfsh_arbiter.sv
// Owed/overdue bookkeeping, refresh start decision and bus grant (R3, R4, R6..R9).
module rfsh_arbiter (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic wrap_i,
  input  logic bus_idle_i,
  input  logic cyc_done_i,
  input  logic page_mode_i,
  input  logic bus_req_i,
  input  logic fsm_idle_i,
  input  logic fin_i,
  output logic start_o,
  output logic pend_o,
  output logic grant_o
);
  logic due_q, due_d;
  logic pend_q, pend_d;
  logic srv_q, srv_d;
  logic grant_q, grant_d;
  logic elig, take_pend, take_due, start_due;

  assign elig      = en_i && fsm_idle_i && !grant_q && !page_mode_i;
  assign take_pend = pend_q && (bus_idle_i || cyc_done_i);
  assign take_due  = due_q && bus_idle_i;
  assign start_o   = elig && (take_pend || take_due);
  assign start_due = start_o && !pend_q;
  assign pend_o    = pend_q;
  assign grant_o   = grant_q;

  always_comb begin
    due_d = due_q;
    if (wrap_i)         due_d = 1'b1;
    else if (start_due) due_d = 1'b0;
  end

  always_comb begin
    pend_d = pend_q;
    if (wrap_i && due_q && !start_due) pend_d = 1'b1;
    else if (fin_i && srv_q)           pend_d = 1'b0;
  end

  always_comb begin
    srv_d = srv_q;
    if (start_o) srv_d = pend_q;
  end

  always_comb begin
    if (grant_q) grant_d = bus_req_i;
    else         grant_d = bus_req_i && !page_mode_i && fsm_idle_i && !start_o;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      due_q   <= 1'b0;
      pend_q  <= 1'b0;
      srv_q   <= 1'b0;
      grant_q <= 1'b0;
    end else begin
      due_q   <= due_d;
      pend_q  <= pend_d;
      srv_q   <= srv_d;
      grant_q <= grant_d;
    end
  end
endmodule

// File: rtl/rfsh_sched.sv
module rfsh_sched #(
  parameter int CNT_W      = 12,
  parameter int PHASE_CLKS = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic [CNT_W-1:0] reload_i,
  input  logic             bus_idle_i,
  input  logic             cyc_done_i,
  input  logic             page_mode_i,
  input  logic             bus_req_i,
  output logic             cas_n_o,
  output logic             ras_n_o,
  output logic             bus_grant_o,
  output logic             pending_o
);
  logic [CNT_W-1:0] cnt_w;
  logic             wrap_w, start_w, idle_w, fin_w;

  rfsh_interval #(.CNT_W(CNT_W)) u_interval (
    .clk      (clk),
    .rst_n    (rst_n),
    .en_i     (en_i),
    .reload_i (reload_i),
    .cnt_o    (cnt_w),
    .wrap_o   (wrap_w)
  );

  rfsh_arbiter u_arb (
    .clk         (clk),
    .rst_n       (rst_n),
    .en_i        (en_i),
    .wrap_i      (wrap_w),
    .bus_idle_i  (bus_idle_i),
    .cyc_done_i  (cyc_done_i),
    .page_mode_i (page_mode_i),
    .bus_req_i   (bus_req_i),
    .fsm_idle_i  (idle_w),
    .fin_i       (fin_w),
    .start_o     (start_w),
    .pend_o      (pending_o),
    .grant_o     (bus_grant_o)
  );

  rfsh_strobe_fsm #(.PHASE_CLKS(PHASE_CLKS)) u_fsm (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_w),
    .idle_o  (idle_w),
    .fin_o   (fin_w),
    .cas_n_o (cas_n_o),
    .ras_n_o (ras_n_o)
  );
endmodule

// File: rtl/rfsh_sched_chk.sv
module rfsh_sched_chk #(
  parameter int CNT_W = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en_i,
  input logic             page_mode_i,
  input logic             bus_req_i,
  input logic             cas_n_o,
  input logic             ras_n_o,
  input logic             bus_grant_o,
  input logic             pending_o,
  input logic [CNT_W-1:0] cnt_q
);
  assert_cnt_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> $stable(cnt_q));

  assert_cas_first_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n_o) |-> (!cas_n_o && $past(!cas_n_o)));

  assert_ras_inside_cas_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !ras_n_o |-> !cas_n_o);

  assert_no_start_page_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cas_n_o) |-> $past(!page_mode_i));

  assert_grant_rule_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_grant_o) |-> $past(bus_req_i && !page_mode_i));

  assert_quiet_granted_R8: assert property (@(posedge clk) disable iff (!rst_n)
    bus_grant_o |-> (cas_n_o && ras_n_o));

  assert_pend_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pending_o) |-> $past(!ras_n_o));
endmodule

bind rfsh_sched rfsh_sched_chk #(.CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .en_i        (en_i),
  .page_mode_i (page_mode_i),
  .bus_req_i   (bus_req_i),
  .cas_n_o     (cas_n_o),
  .ras_n_o     (ras_n_o),
  .bus_grant_o (bus_grant_o),
  .pending_o   (pending_o),
  .cnt_q       (cnt_w)
);

// File: tb/rfsh_sched_tb.sv
`timescale 1ns/1ps
module rfsh_sched_tb;
  localparam int CW = 8;
  localparam int PH = 2;

  logic clk = 1'b0;
  logic rst_n;
  logic en, idle, done, page, req;
  logic [CW-1:0] reload;
  logic cas_n, ras_n, grant, pend;
  int   n_tests = 0, n_fail = 0;
  bit   finished = 1'b0;

  always #2 clk = ~clk;

  rfsh_sched #(.CNT_W(CW), .PHASE_CLKS(PH)) u_dut (
    .clk(clk), .rst_n(rst_n), .en_i(en), .reload_i(reload),
    .bus_idle_i(idle), .cyc_done_i(done), .page_mode_i(page),
    .bus_req_i(req), .cas_n_o(cas_n), .ras_n_o(ras_n),
    .bus_grant_o(grant), .pending_o(pend)
  );

  // Reference model built from the requirements.
  int m_cnt, m_ph, m_pc;
  bit m_due, m_pend, m_srv, m_grant;

  function automatic bit exp_cas_n(int ph); return ph == 0; endfunction
  function automatic bit exp_ras_n(int ph); return ph != 2; endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_ph = 0; m_pc = 0;
      m_due = 0; m_pend = 0; m_srv = 0; m_grant = 0;
    end else begin
      bit wrap, fsm_idle, start, start_due, fin;
      wrap      = en && (m_cnt == 0);
      fsm_idle  = (m_ph == 0);
      start     = en && fsm_idle && !m_grant && !page &&
                  ((m_pend && (idle || done)) || (m_due && idle));
      start_due = start && !m_pend;
      fin       = (m_ph == 2) && (m_pc == PH - 1);
      if (wrap && m_due && !start_due) m_pend = 1;
      else if (fin && m_srv)           m_pend = 0;
      if (wrap)           m_due = 1;
      else if (start_due) m_due = 0;
      if (start) m_srv = m_pend | !start_due ? !start_due : 0;
      m_grant = m_grant ? req : (req && !page && fsm_idle && !start);
      if (en) m_cnt = (m_cnt == 0) ? int'(reload) : m_cnt - 1;
      case (m_ph)
        0: if (start) begin m_ph = 1; m_pc = 0; end
        1: if (m_pc == PH - 1) begin m_ph = 2; m_pc = 0; end else m_pc++;
        default: if (m_pc == PH - 1) begin m_ph = 0; m_pc = 0; end else m_pc++;
      endcase
    end
  end

  task automatic chk(string tag, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic cmp_model();
    chk("R5 cas_n vs model", cas_n, exp_cas_n(m_ph));
    chk("R5 ras_n vs model", ras_n, exp_ras_n(m_ph));
    chk("R7 grant vs model", grant, m_grant);
    chk("R9 pending vs model", pend, m_pend);
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    cmp_model();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int k;
    int low_cnt;
    void'($urandom(32'h5EED_0042));
    rst_n = 0; en = 0; idle = 0; done = 0; page = 0; req = 0; reload = '0;
    repeat (3) @(negedge clk);
    // R10: reset state
    chk("R10 cas_n in reset", cas_n, 1);
    chk("R10 ras_n in reset", ras_n, 1);
    chk("R10 grant in reset", grant, 0);
    chk("R10 pending in reset", pend, 0);
    rst_n = 1;

    // R1: disabled, idle bus, no refresh
    idle = 1; reload = 8'd3;
    low_cnt = 0;
    for (int i = 0; i < 20; i++) begin step(); if (!cas_n) low_cnt++; end
    chk("R1 no strobe while disabled", low_cnt, 0);

    // R2/R4: period of reload+1 clocks, overdue flag after unserved period
    idle = 0; reload = 8'd9; en = 1;
    k = -1;
    for (int i = 0; i < 40; i++) begin
      step();
      if (pend) begin k = i; break; end
    end
    chk("R2 R4 clocks until overdue", k, 10);
    step(); step();
    chk("R4 no forced start without done", cas_n, 1);
    done = 1;
    step(); done = 0;
    chk("R4 forced start on cycle done", cas_n, 0);
    chk("R5 cas only phase", ras_n, 1);
    step();
    chk("R5 cas phase second clock", {cas_n, ras_n}, 2'b01);
    step();
    chk("R5 ras phase", {cas_n, ras_n}, 2'b00);
    step();
    chk("R5 ras phase second clock", {cas_n, ras_n}, 2'b00);
    chk("R9 pending held until end", pend, 1);
    step();
    chk("R5 strobes released", {cas_n, ras_n}, 2'b11);
    chk("R9 pending cleared after refresh", pend, 0);

    // R6/R7: page mode blocks refresh and grant
    page = 1; req = 1; idle = 1;
    low_cnt = 0; k = 0;
    for (int i = 0; i < 30; i++) begin
      step(); if (!cas_n) low_cnt++; if (grant) k++;
    end
    chk("R6 no refresh in page mode", low_cnt, 0);
    chk("R7 no grant in page mode", k, 0);
    chk("R4 overdue during page mode", pend, 1);
    idle = 0; page = 0;
    step();
    chk("R7 grant after page release", grant, 1);

    // R8: granted bus holds off overdue refresh
    idle = 1; done = 1;
    low_cnt = 0;
    for (int i = 0; i < 25; i++) begin step(); if (!cas_n) low_cnt++; end
    chk("R8 no refresh while granted", low_cnt, 0);
    chk("R8 overdue kept while granted", pend, 1);
    req = 0;
    step();
    chk("R7 grant drops after request", grant, 0);
    step();
    chk("R8 overdue refresh after bus returns", cas_n, 0);
    done = 0; idle = 0;

    // Random phase with model comparison
    for (int i = 0; i < 20000; i++) begin
      en   = ($urandom % 16) != 0;
      idle = ($urandom % 3) == 0;
      done = ($urandom % 4) == 0;
      if (($urandom % 20) == 0) req = ~req;
      if (($urandom % 40) == 0) page = ~page;
      if (grant) page = 0;
      if (($urandom % 500) == 0) reload = CW'($urandom % 24);
      step();
    end

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule